// File: doc/BRIEF.md
# Serial Port Interrupt Arbiter

This block sits beside a serial receiver and transmitter and turns their event signals into one shared interrupt request, a vector code and DMA request strobes. Each receive cause (data ready, overrun, framing error, parity error, address hit, break) and one transmit cause has a sticky status bit. Software reads these bits to find the cause that raised the shared request, then clears each bit by writing 1 to it. A control bit chooses which transmit event counts: buffer empty or shift register empty.

Four levels compete under a fixed priority. From highest to lowest they are receive DMA, transmit DMA, receive interrupt and transmit interrupt. The winning level is encoded as two bits that are placed inside a software base vector, so each level selects its own slot in an 8-byte block of pointers. While the interrupt controller acknowledges a request, the level code is frozen.

Top module: `sci_irq_arbiter`

## Requirements
- R1: Each receive event input sets its status bit on the next clock edge, and the bit stays set after the input drops. The bit positions are: data ready 0, overrun 1, framing 2, parity 3, address hit 4, break 5.
- R2: Status bit 6 is the transmit cause. When control bit 0 (register 2) is 1, it is set by `tx_buf_empty`; when it is 0, it is set by `tx_shift_empty`. The unselected input has no effect.
- R3: Writing register 0 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When a status bit is set by an event and cleared by software on the same edge, the bit ends up set.
- R5: Register 1 holds one enable bit per status position. `irq_req` is high whenever a status bit and its enable bit are both 1, and it goes low in the cycle after the write that clears the last such bit.
- R6: The level code is 0 for receive DMA, 1 for transmit DMA, 2 for an enabled receive status bit and 3 for an enabled transmit status bit, with that order as the priority. The code is registered, so it follows its inputs by one edge. It keeps its value when nothing is active.
- R7: `irq_vec` equals the base register with bits [2:1] set to the level code and bit 0 set to 0. The low three bits of the base register always read as 0.
- R8: While `irq_ack` is high, the level code does not change.
- R9: `rx_dma_stb` is high in the cycle after `rx_dma_req` is high. `tx_dma_stb` is high in the cycle after `tx_dma_req` is high, but only if `rx_dma_req` was low in that same cycle. The two strobes are never high together.
- R10: After reset, status, enables, control and base are all 0, and `irq_req`, `irq_vec` and both strobes are 0.
- R11: The read data is combinational from `bus_addr`. Address 0 returns status, 1 returns the enables, 2 returns the control bit in bit 0, and 3 returns the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_data_rdy | input | 1 | Received data ready event |
| rx_overrun | input | 1 | Receive overrun event |
| rx_frame_err | input | 1 | Framing error event |
| rx_parity_err | input | 1 | Parity error event |
| rx_addr_hit | input | 1 | Address match event |
| rx_break | input | 1 | Break detected event |
| tx_buf_empty | input | 1 | Transmit buffer empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_dma_req | input | 1 | Receive DMA request |
| tx_dma_req | input | 1 | Transmit DMA request |
| irq_ack | input | 1 | Interrupt acknowledge in progress |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data |
| irq_req | output | 1 | Shared interrupt request |
| irq_vec | output | VEC_W | Base vector with the level code in bits [2:1] |
| rx_dma_stb | output | 1 | Receive DMA strobe |
| tx_dma_stb | output | 1 | Transmit DMA strobe |

## Verification
A status bit that wrongly sets or clears appears on `bus_rdata` during the very next cycle. It also moves `irq_req` in that cycle if the bit is enabled, and it moves the level code one edge later. A wrong priority decision or a wrong acknowledge freeze shows in `irq_vec` one edge after the deciding inputs. A reference model compares every output on every clock, so each of these faults is caught within one or two cycles of its cause.

// File: rtl/sci_irq_pkg.sv
package sci_irq_pkg;
   localparam int N_RX_CAUSE = 6;
   localparam int N_STAT     = N_RX_CAUSE + 1;
   localparam int TX_BIT     = N_RX_CAUSE;

   typedef enum logic [1:0] {
      LVL_RX_DMA = 2'd0,
      LVL_TX_DMA = 2'd1,
      LVL_RX_INT = 2'd2,
      LVL_TX_INT = 2'd3
   } level_t;

   localparam logic [1:0] REG_STATUS = 2'd0;
   localparam logic [1:0] REG_ENABLE = 2'd1;
   localparam logic [1:0] REG_CTRL   = 2'd2;
   localparam logic [1:0] REG_BASE   = 2'd3;
endpackage

// File: rtl/sci_irq_status.sv
module sci_irq_status #(
   parameter int NB       = 7,
   parameter bit SET_WINS = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NB-1:0] set_in,
   input  logic [NB-1:0] clr_in,
   output logic [NB-1:0] status_q
);
   for (genvar i = 0; i < NB; i++) begin : g_bit
      logic bit_q;
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= set_in[i] | (bit_q & ~clr_in[i]);
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= (bit_q | set_in[i]) & ~clr_in[i];
         end
      end
      assign status_q[i] = bit_q;
   end

   if (SET_WINS) begin : g_chk_set
      AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> ((status_q & $past(set_in)) == $past(set_in))); // R4
   end

   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(clr_in & ~set_in)) == '0)); // R3

   AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((status_q ^ $past(status_q)) & ~$past(set_in | clr_in)) == '0)); // R1
endmodule

// File: rtl/sci_irq_regs.sv
module sci_irq_regs
   import sci_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 2,
   parameter int VEC_W  = 8,
   parameter int NB     = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [NB-1:0]     status_q,
   output logic [NB-1:0]     clr,
   output logic [NB-1:0]     en_q,
   output logic              tx_sel_q,
   output logic [VEC_W-4:0]  base_hi_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int HI_W = VEC_W - 3;

   logic hit_stat, hit_en, hit_ctrl, hit_base;
   assign hit_stat = wr && (addr == ADDR_W'(REG_STATUS));
   assign hit_en   = wr && (addr == ADDR_W'(REG_ENABLE));
   assign hit_ctrl = wr && (addr == ADDR_W'(REG_CTRL));
   assign hit_base = wr && (addr == ADDR_W'(REG_BASE));

   assign clr = hit_stat ? wdata[NB-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= '0;
         tx_sel_q  <= 1'b0;
         base_hi_q <= '0;
      end else begin
         if (hit_en)   en_q      <= wdata[NB-1:0];
         if (hit_ctrl) tx_sel_q  <= wdata[0];
         if (hit_base) base_hi_q <= wdata[VEC_W-1:3];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(REG_STATUS))      rdata[NB-1:0] = status_q;
      else if (addr == ADDR_W'(REG_ENABLE)) rdata[NB-1:0] = en_q;
      else if (addr == ADDR_W'(REG_CTRL))   rdata[0]      = tx_sel_q;
      else if (addr == ADDR_W'(REG_BASE))   rdata[VEC_W-1:3] = base_hi_q[HI_W-1:0];
   end

   AST_ENABLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      hit_en |=> (en_q == $past(wdata[NB-1:0]))); // R5
endmodule

// File: rtl/sci_irq_prio.sv
module sci_irq_prio
   import sci_irq_pkg::*;
#(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_dma_req,
   input  logic             tx_dma_req,
   input  logic             rx_pend,
   input  logic             tx_pend,
   input  logic             irq_ack,
   input  logic [VEC_W-4:0] base_hi,
   output logic [VEC_W-1:0] vec,
   output logic             rx_stb,
   output logic             tx_stb
);
   level_t win, lvl_q;
   logic   any_act;

   assign any_act = rx_dma_req | tx_dma_req | rx_pend | tx_pend;

   always_comb begin
      if (rx_dma_req)      win = LVL_RX_DMA;
      else if (tx_dma_req) win = LVL_TX_DMA;
      else if (rx_pend)    win = LVL_RX_INT;
      else                 win = LVL_TX_INT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= LVL_RX_DMA;
         rx_stb <= 1'b0;
         tx_stb <= 1'b0;
      end else begin
         if (!irq_ack && any_act) lvl_q <= win;
         rx_stb <= rx_dma_req;
         tx_stb <= tx_dma_req & ~rx_dma_req;
      end
   end

   assign vec = {base_hi, lvl_q, 1'b0};

   AST_ACK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ack |=> $stable(lvl_q)); // R8
   AST_RXDMA_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_dma_req && !irq_ack) |=> (lvl_q == LVL_RX_DMA)); // R6
   AST_RXDMA_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_dma_req |=> (rx_stb && !tx_stb)); // R9
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !any_act |=> $stable(lvl_q)); // R6
endmodule

// File: rtl/sci_irq_arbiter.sv
module sci_irq_arbiter
   import sci_irq_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 2,
   parameter int VEC_W    = 8,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_data_rdy,
   input  logic              rx_overrun,
   input  logic              rx_frame_err,
   input  logic              rx_parity_err,
   input  logic              rx_addr_hit,
   input  logic              rx_break,
   input  logic              tx_buf_empty,
   input  logic              tx_shift_empty,
   input  logic              rx_dma_req,
   input  logic              tx_dma_req,
   input  logic              irq_ack,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic              rx_dma_stb,
   output logic              tx_dma_stb
);
   localparam int NB = N_STAT;

   if (DATA_W < NB)                    begin : g_bad_data  $error("DATA_W too small for status"); end
   if (VEC_W < 4 || VEC_W > DATA_W)    begin : g_bad_vec   $error("VEC_W out of range"); end
   if (ADDR_W < 2)                     begin : g_bad_addr  $error("ADDR_W too small"); end

   logic [NB-1:0]    set_v, clr_v, stat_q, en_q;
   logic             tx_sel_q, tx_evt, rx_pend, tx_pend;
   logic [VEC_W-4:0] base_hi;

   assign tx_evt = tx_sel_q ? tx_buf_empty : tx_shift_empty;
   assign set_v  = {tx_evt, rx_break, rx_addr_hit, rx_parity_err,
                    rx_frame_err, rx_overrun, rx_data_rdy};

   sci_irq_status #(.NB(NB), .SET_WINS(SET_WINS)) u_status (
      .clk(clk), .rst_n(rst_n), .set_in(set_v), .clr_in(clr_v), .status_q(stat_q));

   sci_irq_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .VEC_W(VEC_W), .NB(NB)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .status_q(stat_q), .clr(clr_v), .en_q(en_q), .tx_sel_q(tx_sel_q),
      .base_hi_q(base_hi), .rdata(bus_rdata));

   assign rx_pend = |(stat_q[N_RX_CAUSE-1:0] & en_q[N_RX_CAUSE-1:0]);
   assign tx_pend = stat_q[TX_BIT] & en_q[TX_BIT];
   assign irq_req = rx_pend | tx_pend;

   sci_irq_prio #(.VEC_W(VEC_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
      .rx_pend(rx_pend), .tx_pend(tx_pend), .irq_ack(irq_ack), .base_hi(base_hi),
      .vec(irq_vec), .rx_stb(rx_dma_stb), .tx_stb(tx_dma_stb));

   AST_TX_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_sel_q && tx_buf_empty) |=> stat_q[TX_BIT]); // R2
   AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_dma_stb && tx_dma_stb)); // R9
endmodule

// File: tb/sci_irq_arbiter_test.sv
module sci_irq_arbiter_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_data_rdy = 0, rx_overrun = 0, rx_frame_err = 0, rx_parity_err = 0;
   logic rx_addr_hit = 0, rx_break = 0, tx_buf_empty = 0, tx_shift_empty = 0;
   logic rx_dma_req = 0, tx_dma_req = 0, irq_ack = 0, bus_wr = 0;
   logic [1:0] bus_addr = 0;
   logic [7:0] bus_wdata = 0;
   logic [7:0] bus_rdata, irq_vec;
   logic irq_req, rx_dma_stb, tx_dma_stb;

   int checks = 0, failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   sci_irq_arbiter uut (.*);

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // reference model
   logic [6:0] m_stat = 0, m_en = 0, setv, clrv;
   logic       m_ctrl = 0, m_rxs = 0, m_txs = 0, tx_ev, rxp, txp;
   logic [7:0] m_base = 0, m_rd;
   int         m_lvl = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stat = 0; m_en = 0; m_ctrl = 0; m_base = 0; m_lvl = 0; m_rxs = 0; m_txs = 0;
      end else begin
         tx_ev = m_ctrl ? tx_buf_empty : tx_shift_empty;
         setv  = {tx_ev, rx_break, rx_addr_hit, rx_parity_err, rx_frame_err, rx_overrun, rx_data_rdy};
         clrv  = (bus_wr && bus_addr == 0) ? bus_wdata[6:0] : 7'h0;
         rxp   = |(m_stat[5:0] & m_en[5:0]);
         txp   = m_stat[6] & m_en[6];
         if (!irq_ack) begin
            if (rx_dma_req)      m_lvl = 0;
            else if (tx_dma_req) m_lvl = 1;
            else if (rxp)        m_lvl = 2;
            else if (txp)        m_lvl = 3;
         end
         m_rxs  = rx_dma_req;
         m_txs  = tx_dma_req && !rx_dma_req;
         m_stat = (m_stat & ~clrv) | setv;
         if (bus_wr && bus_addr == 1) m_en   = bus_wdata[6:0];
         if (bus_wr && bus_addr == 2) m_ctrl = bus_wdata[0];
         if (bus_wr && bus_addr == 3) m_base = bus_wdata & 8'hF8;
      end
      #2;
      if (rst_n) begin
         case (bus_addr)
            2'd0: m_rd = {1'b0, m_stat};
            2'd1: m_rd = {1'b0, m_en};
            2'd2: m_rd = {7'b0, m_ctrl};
            default: m_rd = m_base;
         endcase
         chk("R5 model irq_req", irq_req, |(m_stat & m_en));
         chk("R6/R7 model irq_vec", irq_vec, m_base | (m_lvl << 1));
         chk("R9 model rx_dma_stb", rx_dma_stb, m_rxs);
         chk("R9 model tx_dma_stb", tx_dma_stb, m_txs);
         chk("R11 model bus_rdata", bus_rdata, m_rd);
      end
   end

   task automatic tick(); @(negedge clk); endtask

   task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 0; bus_wdata = 0;
   endtask

   task automatic rd(input logic [1:0] a, input int exp, input string tag);
      bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
   endtask

   initial begin
      #(8 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) tick();
      rst_n = 1;
      // R10 reset state
      chk("R10 irq_req after reset", irq_req, 0);
      chk("R10 irq_vec after reset", irq_vec, 0);
      chk("R10 strobes after reset", {rx_dma_stb, tx_dma_stb}, 0);
      rd(0, 0, "R10 status after reset");
      rd(1, 0, "R10 enables after reset");
      rd(3, 0, "R10 base after reset");

      // R1 sticky set, enable off keeps irq low
      rx_data_rdy = 1; tick(); rx_data_rdy = 0;
      rd(0, 8'h01, "R1 data ready sets bit 0");
      chk("R5 no irq with enable off", irq_req, 0);
      {rx_overrun, rx_frame_err, rx_parity_err, rx_addr_hit, rx_break} = 5'h1F; tick();
      {rx_overrun, rx_frame_err, rx_parity_err, rx_addr_hit, rx_break} = 5'h00;
      rd(0, 8'h3F, "R1 all receive causes latched");
      tick();
      rd(0, 8'h3F, "R1 bits hold after inputs drop");

      // R5 enable
      wr_reg(1, 8'h01);
      chk("R5 irq with enabled bit", irq_req, 1);
      // R3 clear
      wr_reg(0, 8'h3E);
      rd(0, 8'h01, "R3 partial clear");
      chk("R5 irq still up", irq_req, 1);
      wr_reg(0, 8'h01);
      chk("R5 irq drops after last clear", irq_req, 0);
      rx_data_rdy = 1; tick(); rx_data_rdy = 0;
      wr_reg(0, 8'h00);
      rd(0, 8'h01, "R3 write of zero keeps bits");

      // R4 set beats clear
      bus_wr = 1; bus_addr = 0; bus_wdata = 8'h01; rx_data_rdy = 1;
      tick();
      bus_wr = 0; bus_wdata = 0; rx_data_rdy = 0;
      rd(0, 8'h01, "R4 set wins over clear");
      wr_reg(0, 8'h01);
      rd(0, 8'h00, "R3 clear after collision");

      // R2 transmit source select
      tx_buf_empty = 1; tick(); tx_buf_empty = 0;
      rd(0, 8'h00, "R2 buffer-empty ignored when select=0");
      tx_shift_empty = 1; tick(); tx_shift_empty = 0;
      rd(0, 8'h40, "R2 shift-empty sets bit 6 when select=0");
      wr_reg(0, 8'h40);
      wr_reg(2, 8'h01);
      tx_shift_empty = 1; tick(); tx_shift_empty = 0;
      rd(0, 8'h00, "R2 shift-empty ignored when select=1");
      tx_buf_empty = 1; tick(); tx_buf_empty = 0;
      rd(0, 8'h40, "R2 buffer-empty sets bit 6 when select=1");
      wr_reg(0, 8'h7F);

      // R7 / R11 base and read map
      wr_reg(3, 8'hFF);
      rd(3, 8'hF8, "R7 base low bits read zero");
      rd(2, 8'h01, "R11 control read");
      rd(1, 8'h01, "R11 enable read");
      wr_reg(1, 8'h7F);
      tick();

      // R6 priority levels
      tx_buf_empty = 1; tick(); tx_buf_empty = 0; tick();
      chk("R6 transmit interrupt level 3", irq_vec, 8'hFE);
      rx_data_rdy = 1; tick(); rx_data_rdy = 0; tick();
      chk("R6 receive interrupt beats transmit", irq_vec, 8'hFC);
      tx_dma_req = 1; tick(); tx_dma_req = 0;
      chk("R6 transmit DMA level 1", irq_vec, 8'hFA);
      chk("R9 transmit strobe alone", {rx_dma_stb, tx_dma_stb}, 2'b01);
      rx_dma_req = 1; tx_dma_req = 1; tick(); rx_dma_req = 0; tx_dma_req = 0;
      chk("R6 receive DMA level 0", irq_vec, 8'hF8);
      chk("R9 receive strobe wins", {rx_dma_stb, tx_dma_stb}, 2'b10);
      tick();
      chk("R6 back to receive interrupt", irq_vec, 8'hFC);
      chk("R9 strobes drop", {rx_dma_stb, tx_dma_stb}, 2'b00);

      // R8 acknowledge freeze
      irq_ack = 1; rx_dma_req = 1; tick(); tick();
      chk("R8 level frozen during ack", irq_vec, 8'hFC);
      irq_ack = 0; tick(); rx_dma_req = 0;
      chk("R8 level moves after ack", irq_vec, 8'hF8);

      // R6 hold when idle
      wr_reg(0, 8'h7F);
      tick(); tick();
      chk("R6 level held when idle", irq_vec, 8'hFC);
      chk("R5 irq low when idle", irq_req, 0);

      // R1 reading every position again
      rx_break = 1; tick(); rx_break = 0;
      rd(0, 8'h20, "R1 break sets bit 5");
      repeat (2) tick();
      finish_run();
   end
endmodule